// File: doc/BRIEF.md
# Compare and Branch Resolver

This block is the condition unit of a small 16-bit processor. A compare operation reads two signed 16-bit operands and records the result as three mutually exclusive condition flags: less, equal and greater. The flags stay as they are until the next compare.

A jump operation presents a 4-bit condition opcode, the addressing mode of its operand, a target address, the current program counter and the instruction length. The block checks the stored flags against the opcode. It also rejects addressing modes that cannot name a jump target. One cycle later it reports whether the jump is taken, whether it was illegal, and the next program counter.

The no-operation opcode shares the jump opcode space. It carries no meaningful address.

Top module: `branch_resolver`

## Requirements
- R1: While `rst_n` is low, and after it is released, the flags read less=0, equal=1, greater=0, `res_valid` reads 0, and `res_taken`, `res_err` and `res_pc` read 0.
- R2: The edge that samples `cmp_valid`=1 sets exactly one flag. The flag is chosen by comparing `cmp_a` and `cmp_b` as two's-complement values: less when a<b, equal when a==b, greater when a>b.
- R3: The flags change only on a compare. Idle cycles and jump operations, legal or illegal, leave them as they were.
- R4: Opcode codes and their conditions on the stored flags are: 1 always taken, 2 when less, 3 when less or equal, 4 when equal, 5 when not equal, 6 when greater or equal, 7 when greater.
- R5: Opcode 0 is the no-operation code. It is never taken and never flagged illegal, whatever `jmp_mode` and `jmp_two_word` hold. Its next PC is `cur_pc`+1.
- R6: Addressing mode codes 0 (register direct) and 3 (immediate) on opcodes 1..7 set `res_err`. Such a jump is not taken. Codes 1, 2, 4, 5, 6 and 7 are legal.
- R7: Opcodes 8..15 are reserved. They set `res_err` and are not taken.
- R8: A taken jump gives `res_pc` equal to the low 15 bits of `jmp_target`.
- R9: A jump that is not taken, or is illegal, gives `res_pc` = `cur_pc` + 2 when `jmp_two_word` is 1, and `cur_pc` + 1 otherwise. The sum wraps modulo 2^15.
- R10: A jump and a compare may arrive in the same cycle. In that case the jump is judged on the flags held before that compare, and the compare still updates the flags.
- R11: The results appear on the edge that samples `jmp_valid`=1 and are marked by `res_valid`=1 in the following cycle. `res_valid` is 0 after a cycle with no jump. `res_taken`, `res_err` and `res_pc` hold their last values until the next jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Perform a compare this cycle |
| cmp_a | input | 16 | Left compare operand, signed |
| cmp_b | input | 16 | Right compare operand, signed |
| jmp_valid | input | 1 | Resolve a jump this cycle |
| jmp_op | input | 4 | Condition opcode |
| jmp_mode | input | 3 | Addressing mode of the jump operand |
| jmp_two_word | input | 1 | Instruction occupies two words |
| jmp_target | input | 16 | Effective target address |
| cur_pc | input | 15 | Address of the jump instruction |
| flag_lt | output | 1 | Less flag |
| flag_eq | output | 1 | Equal flag |
| flag_gt | output | 1 | Greater flag |
| res_valid | output | 1 | Result registers updated last edge |
| res_taken | output | 1 | Jump taken |
| res_err | output | 1 | Illegal mode or reserved opcode |
| res_pc | output | 15 | Next program counter |

## Verification
A compare and a jump can share a cycle, and the flag register is then both read and written on the same edge. The bench first settles the flags to equal. It then presents the compare 1 vs 2 and an equal-condition jump together. The jump must be reported taken, because it reads the old equal flag. Right after that, the flags must read less, which shows the compare was not lost. A second case pairs an illegal jump with a compare and confirms that the error is reported and the compare still lands.

// File: rtl/branch_resolver.sv
module branch_resolver #(
  parameter int DATA_W = 16,
  parameter int PC_W   = 15,
  parameter int OP_W   = 4,
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  input  logic [DATA_W-1:0] cmp_a,
  input  logic [DATA_W-1:0] cmp_b,
  input  logic              jmp_valid,
  input  logic [OP_W-1:0]   jmp_op,
  input  logic [MODE_W-1:0] jmp_mode,
  input  logic              jmp_two_word,
  input  logic [DATA_W-1:0] jmp_target,
  input  logic [PC_W-1:0]   cur_pc,
  output logic              flag_lt,
  output logic              flag_eq,
  output logic              flag_gt,
  output logic              res_valid,
  output logic              res_taken,
  output logic              res_err,
  output logic [PC_W-1:0]   res_pc
);

  localparam logic [OP_W-1:0]   OP_NOP = OP_W'(0);
  localparam logic [OP_W-1:0]   OP_JMP = OP_W'(1);
  localparam logic [OP_W-1:0]   OP_JLT = OP_W'(2);
  localparam logic [OP_W-1:0]   OP_JLE = OP_W'(3);
  localparam logic [OP_W-1:0]   OP_JEQ = OP_W'(4);
  localparam logic [OP_W-1:0]   OP_JNE = OP_W'(5);
  localparam logic [OP_W-1:0]   OP_JGE = OP_W'(6);
  localparam logic [OP_W-1:0]   OP_JGT = OP_W'(7);
  localparam logic [MODE_W-1:0] M_REG  = MODE_W'(0);
  localparam logic [MODE_W-1:0] M_IMM  = MODE_W'(3);

  logic cmp_lt, cmp_eq;
  assign cmp_lt = $signed(cmp_a) < $signed(cmp_b);
  assign cmp_eq = cmp_a == cmp_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_lt <= 1'b0;
      flag_eq <= 1'b1;
      flag_gt <= 1'b0;
    end else if (cmp_valid) begin
      flag_lt <= cmp_lt;
      flag_eq <= cmp_eq;
      flag_gt <= !cmp_lt && !cmp_eq;
    end
  end

  logic cond_met;
  always_comb begin
    case (jmp_op)
      OP_JMP:  cond_met = 1'b1;
      OP_JLT:  cond_met = flag_lt;
      OP_JLE:  cond_met = flag_lt | flag_eq;
      OP_JEQ:  cond_met = flag_eq;
      OP_JNE:  cond_met = !flag_eq;
      OP_JGE:  cond_met = flag_gt | flag_eq;
      OP_JGT:  cond_met = flag_gt;
      default: cond_met = 1'b0;
    endcase
  end

  logic is_nop, op_known, mode_bad, jump_err, jump_taken;
  assign is_nop     = jmp_op == OP_NOP;
  assign op_known   = jmp_op <= OP_JGT;
  assign mode_bad   = (jmp_mode == M_REG) || (jmp_mode == M_IMM);
  assign jump_err   = !is_nop && (!op_known || mode_bad);
  assign jump_taken = !is_nop && !jump_err && cond_met;

  logic [PC_W-1:0] step, seq_pc, nxt_pc;
  assign step   = (!is_nop && jmp_two_word) ? PC_W'(2) : PC_W'(1);
  assign seq_pc = cur_pc + step;
  assign nxt_pc = jump_taken ? jmp_target[PC_W-1:0] : seq_pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_taken <= 1'b0;
      res_err   <= 1'b0;
      res_pc    <= '0;
    end else begin
      res_valid <= jmp_valid;
      if (jmp_valid) begin
        res_taken <= jump_taken;
        res_err   <= jump_err;
        res_pc    <= nxt_pc;
      end
    end
  end

  a_r2_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({flag_lt, flag_eq, flag_gt}) == 1);

  a_r2_less: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && ($signed(cmp_a) < $signed(cmp_b)) |=> flag_lt);

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid |=> $stable({flag_lt, flag_eq, flag_gt}));

  a_r5_nop: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_valid && jmp_op == OP_NOP |=>
      !res_taken && !res_err && res_pc == PC_W'($past(cur_pc) + 1'b1));

  a_r6_bad_mode: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_valid && jmp_op != OP_NOP && (jmp_mode == M_REG || jmp_mode == M_IMM)
      |=> res_err && !res_taken);

  a_r8_target: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_valid |=> (!res_taken || res_pc == $past(jmp_target[PC_W-1:0])));

  a_r10_old_flags: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_valid && jmp_op == OP_JEQ && !(jmp_mode == M_REG || jmp_mode == M_IMM)
      |=> res_taken == $past(flag_eq));

  a_r11_valid_on: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_valid |=> res_valid);

  a_r11_valid_off: assert property (@(posedge clk) disable iff (!rst_n)
    !jmp_valid |=> !res_valid);

endmodule

// File: tb/branch_resolver_test.sv
module branch_resolver_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_valid = 1'b0;
  logic [15:0] cmp_a = '0, cmp_b = '0;
  logic        jmp_valid = 1'b0;
  logic [3:0]  jmp_op = '0;
  logic [2:0]  jmp_mode = '0;
  logic        jmp_two_word = 1'b0;
  logic [15:0] jmp_target = '0;
  logic [14:0] cur_pc = '0;
  logic        flag_lt, flag_eq, flag_gt;
  logic        res_valid, res_taken, res_err;
  logic [14:0] res_pc;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  branch_resolver uut (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .jmp_valid(jmp_valid), .jmp_op(jmp_op), .jmp_mode(jmp_mode),
    .jmp_two_word(jmp_two_word), .jmp_target(jmp_target), .cur_pc(cur_pc),
    .flag_lt(flag_lt), .flag_eq(flag_eq), .flag_gt(flag_gt),
    .res_valid(res_valid), .res_taken(res_taken), .res_err(res_err), .res_pc(res_pc)
  );

  typedef struct packed {
    logic [15:0] a;
    logic [15:0] b;
    logic [3:0]  op;
    logic [2:0]  mode;
    logic [15:0] tgt;
    logic [14:0] pc;
    logic        two;
    logic        ex_taken;
    logic        ex_err;
    logic [14:0] ex_pc;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{16'h0005, 16'h0009, 4'd2, 3'd1, 16'h0123, 15'h0010, 1'b0, 1'b1, 1'b0, 15'h0123},
    '{16'h0005, 16'h0009, 4'd6, 3'd1, 16'h0123, 15'h0010, 1'b0, 1'b0, 1'b0, 15'h0011},
    '{16'hFFFF, 16'h0001, 4'd7, 3'd2, 16'h0999, 15'h0020, 1'b1, 1'b0, 1'b0, 15'h0022},
    '{16'h0007, 16'h0007, 4'd4, 3'd4, 16'h8456, 15'h0030, 1'b0, 1'b1, 1'b0, 15'h0456},
    '{16'h0007, 16'h0007, 4'd5, 3'd5, 16'h0100, 15'h7FFF, 1'b1, 1'b0, 1'b0, 15'h0001},
    '{16'h0007, 16'h0007, 4'd3, 3'd6, 16'h0200, 15'h0031, 1'b0, 1'b1, 1'b0, 15'h0200},
    '{16'h7FFF, 16'h8000, 4'd6, 3'd7, 16'h0300, 15'h0032, 1'b0, 1'b1, 1'b0, 15'h0300},
    '{16'h7FFF, 16'h8000, 4'd3, 3'd1, 16'h0300, 15'h0040, 1'b0, 1'b0, 1'b0, 15'h0041},
    '{16'h7FFF, 16'h8000, 4'd1, 3'd2, 16'h1234, 15'h0041, 1'b1, 1'b1, 1'b0, 15'h1234},
    '{16'h7FFF, 16'h8000, 4'd7, 3'd7, 16'h0ABC, 15'h0042, 1'b0, 1'b1, 1'b0, 15'h0ABC},
    '{16'hFFFD, 16'hFFFE, 4'd3, 3'd1, 16'h0055, 15'h0043, 1'b0, 1'b1, 1'b0, 15'h0055},
    '{16'hFFFD, 16'hFFFE, 4'd5, 3'd1, 16'h0066, 15'h0044, 1'b0, 1'b1, 1'b0, 15'h0066},
    '{16'h1111, 16'h1111, 4'd6, 3'd5, 16'h0077, 15'h0045, 1'b0, 1'b1, 1'b0, 15'h0077},
    '{16'h0001, 16'h0002, 4'd2, 3'd0, 16'h0500, 15'h0050, 1'b0, 1'b0, 1'b1, 15'h0051},
    '{16'h0001, 16'h0002, 4'd1, 3'd3, 16'h0500, 15'h0060, 1'b1, 1'b0, 1'b1, 15'h0062},
    '{16'h0001, 16'h0002, 4'd0, 3'd3, 16'h0500, 15'h0070, 1'b1, 1'b0, 1'b0, 15'h0071},
    '{16'h0001, 16'h0002, 4'd9, 3'd1, 16'h0500, 15'h0080, 1'b0, 1'b0, 1'b1, 15'h0081}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_flags(input logic [15:0] a, input logic [15:0] b);
    if ($signed(a) < $signed(b)) return 3'b100;
    if (a == b) return 3'b010;
    return 3'b001;
  endfunction

  task automatic do_cmp(input logic [15:0] a, input logic [15:0] b);
    cmp_valid = 1'b1; cmp_a = a; cmp_b = b;
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  task automatic set_jmp(input logic [3:0] op, input logic [2:0] mode, input logic [15:0] tgt,
                         input logic [14:0] pc, input logic two);
    jmp_valid = 1'b1; jmp_op = op; jmp_mode = mode; jmp_target = tgt;
    cur_pc = pc; jmp_two_word = two;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 flags in reset", {29'd0, flag_lt, flag_eq, flag_gt}, 32'b010);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 flags after reset", {29'd0, flag_lt, flag_eq, flag_gt}, 32'b010);
    check("R1 res_valid", {31'd0, res_valid}, 0);
    check("R1 res regs", {15'd0, res_taken, res_err, res_pc}, 0);

    for (int i = 0; i < NV; i++) begin
      do_cmp(VECS[i].a, VECS[i].b);
      check("R2 flags", {29'd0, flag_lt, flag_eq, flag_gt}, {29'd0, exp_flags(VECS[i].a, VECS[i].b)});
      set_jmp(VECS[i].op, VECS[i].mode, VECS[i].tgt, VECS[i].pc, VECS[i].two);
      @(negedge clk);
      jmp_valid = 1'b0;
      check("R11 res_valid", {31'd0, res_valid}, 1);
      check("R4 R5 R6 R7 taken", {31'd0, res_taken}, {31'd0, VECS[i].ex_taken});
      check("R5 R6 R7 err", {31'd0, res_err}, {31'd0, VECS[i].ex_err});
      check("R8 R9 next pc", {17'd0, res_pc}, {17'd0, VECS[i].ex_pc});
      check("R3 flags after jump", {29'd0, flag_lt, flag_eq, flag_gt},
            {29'd0, exp_flags(VECS[i].a, VECS[i].b)});
      @(negedge clk);
      check("R11 res_valid idle", {31'd0, res_valid}, 0);
      check("R11 res_pc held", {17'd0, res_pc}, {17'd0, VECS[i].ex_pc});
    end

    // R3: idle cycles and an illegal jump leave the greater flag alone
    do_cmp(16'h0009, 16'h0002);
    repeat (4) @(negedge clk);
    check("R3 hold idle", {29'd0, flag_lt, flag_eq, flag_gt}, 32'b001);
    set_jmp(4'd7, 3'd0, 16'h0010, 15'h0100, 1'b0);
    @(negedge clk);
    jmp_valid = 1'b0;
    check("R6 illegal reg direct", {30'd0, res_taken, res_err}, 32'b01);
    check("R3 hold after illegal", {29'd0, flag_lt, flag_eq, flag_gt}, 32'b001);

    // R10: compare and jump together, jump sees old equal flag
    do_cmp(16'h0003, 16'h0003);
    cmp_valid = 1'b1; cmp_a = 16'h0001; cmp_b = 16'h0002;
    set_jmp(4'd4, 3'd1, 16'h0BAD, 15'h0200, 1'b0);
    @(negedge clk);
    cmp_valid = 1'b0; jmp_valid = 1'b0;
    check("R10 taken on old flags", {31'd0, res_taken}, 1);
    check("R10 pc", {17'd0, res_pc}, 32'h0BAD);
    check("R10 compare landed", {29'd0, flag_lt, flag_eq, flag_gt}, 32'b100);

    // R10: illegal jump with compare in same cycle
    cmp_valid = 1'b1; cmp_a = 16'h8000; cmp_b = 16'h8000;
    set_jmp(4'd2, 3'd3, 16'h0BAD, 15'h0300, 1'b1);
    @(negedge clk);
    cmp_valid = 1'b0; jmp_valid = 1'b0;
    check("R10 R6 err", {30'd0, res_taken, res_err}, 32'b01);
    check("R9 illegal two-word pc", {17'd0, res_pc}, 32'h0302);
    check("R10 compare landed eq", {29'd0, flag_lt, flag_eq, flag_gt}, 32'b010);

    // R5: NOP with register mode and two-word flag, still one word
    set_jmp(4'd0, 3'd0, 16'h0777, 15'h7FFF, 1'b1);
    @(negedge clk);
    jmp_valid = 1'b0;
    check("R5 nop reg mode", {30'd0, res_taken, res_err}, 0);
    check("R5 nop wrap pc", {17'd0, res_pc}, 0);

    // R7: highest reserved opcode
    set_jmp(4'd15, 3'd7, 16'h0777, 15'h0010, 1'b1);
    @(negedge clk);
    jmp_valid = 1'b0;
    check("R7 reserved 15", {30'd0, res_taken, res_err}, 32'b01);
    check("R7 R9 pc", {17'd0, res_pc}, 32'h0012);

    // R1: reset in mid-run restores flags
    do_cmp(16'h0000, 16'h0005);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset restores eq", {29'd0, flag_lt, flag_eq, flag_gt}, 32'b010);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule